// File: doc/BRIEF.md
# Four-Beat Double-Rate Burst SRAM Model

This block is a synthesizable behavioural model of a synchronous static RAM. Its read port and its write port run side by side, and both take their addresses from one shared bus. Every access moves a burst of four words. Data crosses the interface once per edge of the input clock pair, and a separate active-low lane mask qualifies each write beat.

The model runs on a single internal clock at twice the word rate, so each internal cycle stands for one K or K# edge. A two-bit phase counter tracks these edges. After reset it cycles through read-slot K rise, read-slot K# rise, write-slot K rise and write-slot K# rise. Four groups of four cycles are shown below only for illustration; the counter simply repeats every four cycles.

The address bus is shared in time. A read command and its address are taken on the first K rise of each four-cycle frame. A write command and its address are taken on the second K rise. The array is split into four banks, and the beat index selects the bank. The address therefore names a four-word group, and the beat supplies the two low word-address bits.

Top module: `ddr_burst_sram`

## Requirements
- R1: While rst_ni is low, and after its release until a read burst arrives, rd_valid_o is 0 and rd_data_o is all zero. The first rising clk_i edge after release is frame cycle 0.
- R2: Frame cycle n is the n-th rising edge after reset release, counted modulo 4. rd_n_i is sampled only in frame cycle 0, and wr_n_i is sampled only in frame cycle 2. A select driven low in any other cycle starts nothing.
- R3: When wr_n_i is low in cycle 2, addr_i is taken as the group address. wr_data_i beat k is taken k cycles later, for k = 0 to 3, and is stored in word k of that group.
- R4: wr_be_n_i bit l is active low and belongs to the beat sampled on the same edge. It enables bits l*LW+LW-1 down to l*LW, where LW = DW/LANES. A lane whose bit is high keeps its earlier contents.
- R5: When wr_n_i is high in cycle 2, no array word changes for that frame, whatever wr_data_i, wr_be_n_i and addr_i carry.
- R6: A read taken on edge E of the group addressed by addr_i makes rd_valid_o high after edges E+3 through E+6. After edge E+3+k, rd_data_o holds word k of the group.
- R7: Reads issued in consecutive frames keep rd_valid_o high with no gap between their bursts.
- R8: A burst already under way completes when rd_n_i goes high. The next edge then drives rd_valid_o low, and rd_data_o is zero whenever rd_valid_o is low.
- R9: A read issued in the same frame as a write to the same group returns the newly written lanes for every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock, one cycle per K or K# edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_n_i | input | 1 | Read port select, active low |
| wr_n_i | input | 1 | Write port select, active low |
| addr_i | input | AW | Shared burst group address |
| wr_data_i | input | DW | Write data beat |
| wr_be_n_i | input | LANES | Lane write enables for the current beat, active low |
| rd_data_o | output | DW | Read data beat |
| rd_valid_o | output | 1 | Read data valid; low stands for the outputs at high impedance |

## Verification
The assertions assume that reset is released so that the first edge after release is frame cycle 0. They also assume that the select inputs are driven to known values from time zero, because the start of a burst is traced back four edges to its command. The stimulus keeps to both assumptions. Selects are driven high from the first instant, reset is released at a falling edge, and each frame is then driven as four whole cycles starting at cycle 0. The bench reads back only groups that it wrote earlier, because the array content is unknown after power-up.

// File: rtl/ddr_burst_sram_pkg.sv
package ddr_burst_sram_pkg;
  localparam int unsigned BEATS = 4;

  typedef enum logic [1:0] {
    PH_RD_K  = 2'd0,
    PH_RD_KN = 2'd1,
    PH_WR_K  = 2'd2,
    PH_WR_KN = 2'd3
  } phase_e;
endpackage

// File: rtl/ddr_sram_phase.sv
module ddr_sram_phase
  import ddr_burst_sram_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_e ph_o
);
  phase_e ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_RD_K;
    else         ph_q <= phase_e'(ph_q + 2'd1);
  end

  assign ph_o = ph_q;
endmodule

// File: rtl/ddr_sram_bank.sv
module ddr_sram_bank #(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 18,
  parameter int unsigned LANES = 2
) (
  input  logic             clk_i,
  input  logic [LANES-1:0] we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned LW    = DW / LANES;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++) begin
      if (we_i[l]) mem_q[waddr_i][l*LW +: LW] <= wdata_i[l*LW +: LW];
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ddr_sram_wr_ctrl.sv
module ddr_sram_wr_ctrl
  import ddr_burst_sram_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned LANES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  phase_e                      ph_i,
  input  logic                        wr_n_i,
  input  logic [AW-1:0]               addr_i,
  input  logic [LANES-1:0]            be_n_i,
  output logic [AW-1:0]               row_o,
  output logic [BEATS-1:0][LANES-1:0] bank_we_o
);
  logic          go;
  logic          act_q, act_cur;
  logic [1:0]    beat_q, beat_cur;
  logic [AW-1:0] row_q;

  assign go       = (ph_i == PH_WR_K) && !wr_n_i;
  assign act_cur  = go || act_q;
  assign beat_cur = go ? 2'd0 : beat_q;
  assign row_o    = go ? addr_i : row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      beat_q <= '0;
      row_q  <= '0;
    end else if (go) begin
      act_q  <= 1'b1;
      beat_q <= 2'd1;
      row_q  <= addr_i;
    end else if (act_q) begin
      beat_q <= beat_q + 2'd1;
      if (beat_q == 2'd3) act_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_we
    assign bank_we_o[g] = (act_cur && beat_cur == 2'(g)) ? ~be_n_i : '0;
  end
endmodule

// File: rtl/ddr_sram_rd_ctrl.sv
module ddr_sram_rd_ctrl
  import ddr_burst_sram_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        ph_i,
  input  logic          rd_n_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] row_o,
  output logic [1:0]    beat_o,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o
);
  logic          go, src_vld;
  logic          pend_q, out_q, vld_q;
  logic [AW-1:0] pend_row_q, out_row_q;
  logic [DW-1:0] data_q;

  assign go = (ph_i == PH_RD_K) && !rd_n_i;

  // beat 0 leaves on the write-slot K# edge, then beats 1..3 on the next three edges
  always_comb begin
    unique case (ph_i)
      PH_WR_KN: beat_o = 2'd0;
      PH_RD_K:  beat_o = 2'd1;
      PH_RD_KN: beat_o = 2'd2;
      default:  beat_o = 2'd3;
    endcase
  end

  assign src_vld = (ph_i == PH_WR_KN) ? pend_q     : out_q;
  assign row_o   = (ph_i == PH_WR_KN) ? pend_row_q : out_row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      out_q      <= 1'b0;
      pend_row_q <= '0;
      out_row_q  <= '0;
      vld_q      <= 1'b0;
      data_q     <= '0;
    end else begin
      vld_q  <= src_vld;
      data_q <= src_vld ? word_i : '0;
      unique case (ph_i)
        PH_RD_K: begin
          pend_q <= go;
          if (go) pend_row_q <= addr_i;
        end
        PH_WR_KN: begin
          out_q     <= pend_q;
          out_row_q <= pend_row_q;
          pend_q    <= 1'b0;
        end
        PH_WR_K:  out_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign rd_valid_o = vld_q;
  assign rd_data_o  = data_q;
endmodule

// File: rtl/ddr_burst_sram.sv
module ddr_burst_sram
  import ddr_burst_sram_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 18,
  parameter int unsigned LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_n_i,
  input  logic             wr_n_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [LANES-1:0] wr_be_n_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_valid_o
);
  phase_e                      ph;
  logic [AW-1:0]               wr_row, rd_row;
  logic [BEATS-1:0][LANES-1:0] bank_we;
  logic [1:0]                  rd_beat;
  logic [BEATS-1:0][DW-1:0]    bank_rdata;
  logic [DW-1:0]               rd_word;

  ddr_sram_phase i_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ph_o  (ph)
  );

  ddr_sram_wr_ctrl #(.AW(AW), .LANES(LANES)) i_wr_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ph_i     (ph),
    .wr_n_i   (wr_n_i),
    .addr_i   (addr_i),
    .be_n_i   (wr_be_n_i),
    .row_o    (wr_row),
    .bank_we_o(bank_we)
  );

  for (genvar g = 0; g < BEATS; g++) begin : g_bank
    ddr_sram_bank #(.AW(AW), .DW(DW), .LANES(LANES)) i_bank (
      .clk_i  (clk_i),
      .we_i   (bank_we[g]),
      .waddr_i(wr_row),
      .wdata_i(wr_data_i),
      .raddr_i(rd_row),
      .rdata_o(bank_rdata[g])
    );
  end

  assign rd_word = bank_rdata[rd_beat];

  ddr_sram_rd_ctrl #(.AW(AW), .DW(DW)) i_rd_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ph_i      (ph),
    .rd_n_i    (rd_n_i),
    .addr_i    (addr_i),
    .row_o     (rd_row),
    .beat_o    (rd_beat),
    .word_i    (rd_word),
    .rd_data_o (rd_data_o),
    .rd_valid_o(rd_valid_o)
  );
endmodule

// File: rtl/ddr_burst_sram_chk.sv
module ddr_burst_sram_chk
  import ddr_burst_sram_pkg::*;
#(
  parameter int unsigned DW    = 18,
  parameter int unsigned LANES = 2
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        rd_n_i,
  input logic                        wr_n_i,
  input phase_e                      ph,
  input logic [BEATS-1:0][LANES-1:0] bank_we,
  input logic [DW-1:0]               rd_data_o,
  input logic                        rd_valid_o
);
  logic rd_cmd;
  assign rd_cmd = (ph == PH_RD_K) && !rd_n_i;

  AST_BURST_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |-> $past(rd_cmd, 4)); // R6
  AST_BURST_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |-> ##1 rd_valid_o ##1 rd_valid_o ##1 rd_valid_o); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> rd_data_o == '0); // R8
  AST_VALID_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rd_valid_o) || $fell(rd_valid_o)) |-> ph == PH_RD_K); // R7
  AST_BEAT0_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bank_we[0]) |-> ph == PH_WR_K); // R3
  AST_WR_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph == PH_WR_K && wr_n_i) |-> bank_we == '0); // R5
  AST_ONE_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({|bank_we[3], |bank_we[2], |bank_we[1], |bank_we[0]})); // R2
endmodule

bind ddr_burst_sram ddr_burst_sram_chk #(.DW(DW), .LANES(LANES)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_n_i    (rd_n_i),
  .wr_n_i    (wr_n_i),
  .ph        (ph),
  .bank_we   (bank_we),
  .rd_data_o (rd_data_o),
  .rd_valid_o(rd_valid_o)
);

// File: tb/test_ddr_burst_sram.sv
module test_ddr_burst_sram;
  localparam int unsigned AW    = 8;
  localparam int unsigned DW    = 18;
  localparam int unsigned LANES = 2;
  localparam int unsigned LW    = DW / LANES;
  localparam int unsigned WORDS = (1 << AW) * 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             rd_n = 1'b1;
  logic             wr_n = 1'b1;
  logic [AW-1:0]    addr = '0;
  logic [DW-1:0]    wdata = '0;
  logic [LANES-1:0] be_n = '1;
  logic [DW-1:0]    rd_data;
  logic             rd_valid;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;

  always #5 clk = ~clk;

  ddr_burst_sram #(.AW(AW), .DW(DW), .LANES(LANES)) i_ddr_burst_sram (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .rd_n_i    (rd_n),
    .wr_n_i    (wr_n),
    .addr_i    (addr),
    .wr_data_i (wdata),
    .wr_be_n_i (be_n),
    .rd_data_o (rd_data),
    .rd_valid_o(rd_valid)
  );

  // reference model
  logic [DW-1:0] mdl [WORDS];
  int unsigned   e = 0;
  bit            w_act = 0;
  int unsigned   w_row, w_beat;
  bit            sv [8];
  int unsigned   sa [8];
  logic [DW-1:0]    carry_d [2];
  logic [LANES-1:0] carry_m [2];

  task automatic check(input string req, input logic av, input logic [DW-1:0] ad,
                       input logic ev, input logic [DW-1:0] ed);
    n_tests++;
    if (av !== ev || ad !== ed) begin
      n_fail++;
      $display("FAIL %s edge %0d: valid=%b data=%h expected valid=%b data=%h",
               req, e, av, ad, ev, ed);
    end
  endtask

  task automatic tick(input string req);
    int unsigned fc = e % 4;
    bit          ev;
    logic [DW-1:0] ed;
    if (fc == 2 && !wr_n) begin
      w_act = 1; w_row = addr; w_beat = 0;
    end
    if (w_act) begin
      for (int l = 0; l < LANES; l++)
        if (!be_n[l]) mdl[w_row*4 + w_beat][l*LW +: LW] = wdata[l*LW +: LW];
      w_beat++;
      if (w_beat == 4) w_act = 0;
    end
    ev = sv[e % 8];
    ed = ev ? mdl[sa[e % 8]] : '0;
    sv[e % 8] = 0;
    if (fc == 0 && !rd_n)
      for (int b = 0; b < 4; b++) begin
        sv[(e + 3 + b) % 8] = 1;
        sa[(e + 3 + b) % 8] = addr * 4 + b;
      end
    @(posedge clk);
    @(negedge clk);
    check(req, rd_valid, rd_data, ev, ed);
    e++;
  endtask

  // one frame: cycles 0..3; write beats 2,3 carry into the next frame
  task automatic frame(input string req, input bit rd, input logic [AW-1:0] ra,
                       input bit wr, input logic [AW-1:0] wa,
                       input logic [4*DW-1:0] wd, input logic [4*LANES-1:0] wm,
                       input bit swap);
    rd_n = swap ? 1'b1 : !rd;  wr_n = swap ? !wr : 1'b1;
    addr = swap ? wa : ra;     wdata = carry_d[0]; be_n = carry_m[0];
    tick(req);
    rd_n = 1'b1; wr_n = 1'b1; addr = AW'($urandom);
    wdata = carry_d[1]; be_n = carry_m[1];
    tick(req);
    rd_n = swap ? !rd : 1'b1;  wr_n = swap ? 1'b1 : !wr;
    addr = swap ? ra : wa;     wdata = wd[0 +: DW]; be_n = wm[0 +: LANES];
    tick(req);
    rd_n = 1'b1; wr_n = 1'b1; addr = AW'($urandom);
    wdata = wd[DW +: DW]; be_n = wm[LANES +: LANES];
    tick(req);
    carry_d[0] = wd[2*DW +: DW]; carry_m[0] = wm[2*LANES +: LANES];
    carry_d[1] = wd[3*DW +: DW]; carry_m[1] = wm[3*LANES +: LANES];
  endtask

  function automatic logic [4*DW-1:0] rnd_burst();
    logic [4*DW-1:0] v;
    for (int i = 0; i < 4; i++) v[i*DW +: DW] = DW'($urandom);
    return v;
  endfunction

  task automatic idle(input string req, input int unsigned n);
    for (int i = 0; i < n; i++) frame(req, 0, '0, 0, '0, rnd_burst(), '0, 0);
  endtask

  task automatic t_reset();
    check("R1", rd_valid, rd_data, 1'b0, '0);
    idle("R1", 1);
  endtask

  task automatic t_write_read();
    for (int g = 0; g < 4; g++) frame("R3", 0, '0, 1, AW'(8'h10 + g), rnd_burst(), '0, 0);
    idle("R3", 1);
    for (int g = 0; g < 4; g++) begin
      frame("R6", 1, AW'(8'h10 + g), 0, '0, rnd_burst(), '1, 0);
      idle("R6", 1);
    end
  endtask

  task automatic t_mask();
    frame("R4", 0, '0, 1, 8'h20, rnd_burst(), '0, 0);
    frame("R4", 0, '0, 1, 8'h20, rnd_burst(), 8'b10_01_11_00, 0);
    frame("R4", 0, '0, 1, 8'h21, rnd_burst(), '0, 0);
    frame("R4", 0, '0, 1, 8'h21, rnd_burst(), 8'b01_10_00_11, 0);
    idle("R4", 1);
    frame("R4", 1, 8'h20, 0, '0, rnd_burst(), '1, 0);
    frame("R4", 1, 8'h21, 0, '0, rnd_burst(), '1, 0);
    idle("R4", 2);
  endtask

  task automatic t_wr_ignored();
    frame("R5", 0, '0, 1, 8'h30, rnd_burst(), '0, 0);
    idle("R5", 1);
    frame("R5", 0, '0, 0, 8'h30, rnd_burst(), '0, 0);
    frame("R2", 0, '0, 1, 8'h30, rnd_burst(), '0, 1);
    frame("R2", 1, 8'h10, 0, '0, rnd_burst(), '0, 1);
    idle("R2", 1);
    frame("R5", 1, 8'h30, 0, '0, rnd_burst(), '1, 0);
    idle("R5", 2);
  endtask

  task automatic t_b2b();
    for (int g = 0; g < 4; g++) frame("R7", 1, AW'(8'h10 + g), 0, '0, rnd_burst(), '1, 0);
    frame("R7", 1, 8'h20, 0, '0, rnd_burst(), '1, 0);
    idle("R7", 2);
  endtask

  task automatic t_deselect();
    frame("R8", 1, 8'h21, 0, '0, rnd_burst(), '1, 0);
    frame("R8", 0, AW'($urandom), 0, '0, rnd_burst(), '1, 0);
    idle("R8", 2);
  endtask

  task automatic t_overlap();
    frame("R9", 1, 8'h11, 1, 8'h11, rnd_burst(), 8'b00_01_10_00, 0);
    frame("R9", 1, 8'h12, 1, 8'h12, rnd_burst(), '0, 0);
    idle("R9", 2);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) sv[i] = 0;
    for (int i = 0; i < WORDS; i++) mdl[i] = '0;
    carry_d[0] = '0; carry_d[1] = '0;
    carry_m[0] = '1; carry_m[1] = '1;
    repeat (3) @(negedge clk);
    check("R1", rd_valid, rd_data, 1'b0, '0);
    rst_ni = 1'b1;
    t_reset();
    t_write_read();
    t_mask();
    t_wr_ignored();
    t_b2b();
    t_deselect();
    t_overlap();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule